// File: doc/BRIEF.md
# LCD Row DMA Cycle Stealer

This block refreshes a 64-row monochrome LCD panel from a framebuffer that sits in the CPU's memory. Once every 1024 CPU clocks it holds the CPU, reads the 16 bytes of one row, and sends each byte to the panel as two 4-bit nibbles with a panel clock at half the CPU rate. It then releases the CPU. The hold can land in the middle of any CPU bus cycle, and the stalled access completes once the row is sent. Rows follow each other at the same spacing from row 0 to row 63 and wrap straight back to row 0, with no extra gap between frames.

The block also supplies the byte that the CPU reads from unmapped address space. That byte is normally the last opcode byte seen on the bus. If the read was stretched across a row transfer, it is the last byte of that row instead. Clearing the display enable stops the refresh once any row already under way has finished. Setting it again restarts at row 0.

Top module: `lcd_row_dma`

## Requirements
- R1: While reset is asserted, cpu_hold_o, mem_rd_o, lcd_clk_o, row_sync_o and frame_sync_o are 0, and lcd_nib_o and open_bus_o are 0.
- R2: If disp_en_i is sampled high at the end of cycle c while the block is idle, cycle c+1 is row 0 slot 0: cpu_hold_o, row_sync_o and frame_sync_o are all 1 in that cycle.
- R3: In a running sequence, row_sync_o pulses for one cycle at slot 0 of each row, and row starts are exactly 1024 cycles apart. Rows run 0..63 and then wrap to 0 with the same spacing. frame_sync_o pulses only at slot 0 of row 0.
- R4: In slot 1+4k of row r (k = 0..15), mem_rd_o is high for one cycle with mem_addr_o = fb_base_i + 16*r + k. mem_rd_o is low in all other slots, so a row makes exactly 16 reads.
- R5: The byte is taken from bus_data_i at the end of slot 2+4k. Its bits [7:4] appear on lcd_nib_o in slots 3+4k and 4+4k, and its bits [3:0] in slots 5+4k and 6+4k. lcd_clk_o is 1 in slots 4+4k and 6+4k only. Outside slots 3..66, lcd_nib_o is 0.
- R6: cpu_hold_o is 1 in slots 0..67 of every row, which ends one cycle after the last nibble slot 66. It is 0 in slots 68..1023.
- R7: While the block is idle (disp_en_i low and no row in progress), cpu_hold_o, mem_rd_o, lcd_clk_o and both sync outputs stay 0.
- R8: If disp_en_i is low in a cycle whose slot is 67 or more, the next cycle is idle. If it is low in an earlier slot, the row completes through slot 67 and then the block goes idle.
- R9: Setting disp_en_i again after the block has gone idle restarts the sequence at row 0 slot 0, with frame_sync_o set. It does not resume the row at which the block stopped.
- R10: open_bus_o takes bus_data_i at the end of any cycle with cpu_fetch_i high and cpu_hold_o low. cpu_fetch_i is ignored while cpu_hold_o is high. At each DMA byte capture, open_bus_o takes the DMA byte, so after a row it holds column 15 of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_en_i | input | 1 | Display enable |
| fb_base_i | input | ADDR_W | Framebuffer base address |
| bus_data_i | input | DATA_W | Memory data bus |
| cpu_fetch_i | input | 1 | CPU opcode fetch in this cycle |
| cpu_hold_o | output | 1 | Holds the CPU off the bus |
| mem_addr_o | output | ADDR_W | DMA read address |
| mem_rd_o | output | 1 | DMA read strobe |
| lcd_nib_o | output | DATA_W/2 | Panel nibble data |
| lcd_clk_o | output | 1 | Panel clock |
| row_sync_o | output | 1 | Start-of-row strobe |
| frame_sync_o | output | 1 | Start-of-frame strobe |
| open_bus_o | output | DATA_W | Value returned on reads of unmapped space |

## Verification
The assertions assume that reset is applied with the clock running, so that the first sampled history holds the reset values. They also assume that fb_base_i stays steady while a row is being read. The byte checks further assume that memory returns data on bus_data_i in the cycle after mem_rd_o and holds it to the end of that cycle. The stimulus keeps the base address constant and answers each read strobe with a two-stage pipeline that lines up with that capture edge. It pulses cpu_fetch_i only from the testbench, with no regard to the hold, so that fetches which should be ignored do occur.

// File: rtl/lcd_dma_pkg.sv
package lcd_dma_pkg;
  typedef struct packed {
    logic hold;
    logic rd;
    logic cap;
    logic nib_vld;
    logic nib_hi;
    logic pclk;
  } slot_ctl_t;
endpackage

// File: rtl/lcd_dma_timer.sv
module lcd_dma_timer #(
  parameter int ROWS      = 64,
  parameter int PERIOD    = 1024,
  parameter int HOLD_LAST = 67,
  localparam int CNT_W    = $clog2(PERIOD),
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [ROW_W-1:0] row_o,
  output logic             row_sync_o,
  output logic             frame_sync_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD_LAST);
  localparam logic [ROW_W-1:0] ROW_MAX  = ROW_W'(ROWS - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      row_q    <= '0;
    end else if (!active_q) begin
      active_q <= en_i;
      cnt_q    <= '0;
      row_q    <= '0;
    end else if (!en_i && cnt_q >= CNT_HOLD) begin
      // stop only once the row window is over
      active_q <= 1'b0;
      cnt_q    <= '0;
      row_q    <= '0;
    end else if (cnt_q == CNT_MAX) begin
      cnt_q <= '0;
      row_q <= (row_q == ROW_MAX) ? ROW_W'(0) : row_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o     = active_q;
  assign cnt_o        = cnt_q;
  assign row_o        = row_q;
  assign row_sync_o   = active_q && (cnt_q == '0);
  assign frame_sync_o = row_sync_o && (row_q == '0);

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && $past(active_q) && cnt_q != '0 |-> cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && $past(active_q) && cnt_q == '0 |-> $past(cnt_q) == CNT_MAX); // R3
  AST_ROW_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_sync_o && $past(active_q) |->
      row_q == (($past(row_q) == ROW_MAX) ? ROW_W'(0) : $past(row_q) + 1'b1)); // R3
  AST_STAY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) && !$past(active_q) |-> !active_q); // R7
  AST_RESTART_ROW0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> row_q == '0 && cnt_q == '0); // R9
endmodule

// File: rtl/lcd_dma_slot.sv
module lcd_dma_slot
  import lcd_dma_pkg::*;
#(
  parameter int COLS  = 16,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  output slot_ctl_t        ctl_o,
  output logic [CNT_W-1:0] rd_idx_o
);
  localparam logic [CNT_W-1:0] XFER      = CNT_W'(COLS * 4);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(COLS * 4 + 3);

  logic [1:0] ph;
  logic       in_rd, in_cap, in_nib;

  // nibble phase counts from slot 3
  assign ph     = cnt_i[1:0] + 2'd1;
  assign in_rd  = cnt_i >= CNT_W'(1) && cnt_i <= XFER;
  assign in_cap = cnt_i >= CNT_W'(2) && cnt_i <= XFER + CNT_W'(1);
  assign in_nib = cnt_i >= CNT_W'(3) && cnt_i <= XFER + CNT_W'(2);

  always_comb begin
    ctl_o.hold    = active_i && cnt_i <= HOLD_LAST;
    ctl_o.rd      = active_i && in_rd && cnt_i[1:0] == 2'd1;
    ctl_o.cap     = active_i && in_cap && cnt_i[1:0] == 2'd2;
    ctl_o.nib_vld = active_i && in_nib;
    ctl_o.nib_hi  = ~ph[1];
    ctl_o.pclk    = ctl_o.nib_vld && ph[0];
  end

  assign rd_idx_o = (cnt_i - CNT_W'(1)) >> 2;

  AST_RD_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.rd |-> ctl_o.hold); // R4
endmodule

// File: rtl/lcd_dma_shift.sv
module lcd_dma_shift
  import lcd_dma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  slot_ctl_t           ctl_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W/2-1:0] nib_o,
  output logic                pclk_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        byte_q <= '0;
    else if (ctl_i.cap) byte_q <= data_i;
  end

  assign nib_o  = !ctl_i.nib_vld ? NIB_W'(0) :
                  ctl_i.nib_hi   ? byte_q[DATA_W-1:NIB_W] : byte_q[NIB_W-1:0];
  assign pclk_o = ctl_i.pclk;

  AST_NIB_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_o |-> $stable(nib_o)); // R5
endmodule

// File: rtl/lcd_open_bus.sv
module lcd_open_bus #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic              hold_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] ob_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ob_o <= '0;
    else if (cap_i)              ob_o <= data_i;
    else if (fetch_i && !hold_i) ob_o <= data_i;
  end

  AST_OB_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) && !$past(cap_i) |-> $stable(ob_o)); // R10
endmodule

// File: rtl/lcd_row_dma.sv
module lcd_row_dma
  import lcd_dma_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int COLS   = 16,
  parameter int PERIOD = 1024,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                disp_en_i,
  input  logic [ADDR_W-1:0]   fb_base_i,
  input  logic [DATA_W-1:0]   bus_data_i,
  input  logic                cpu_fetch_i,
  output logic                cpu_hold_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_rd_o,
  output logic [DATA_W/2-1:0] lcd_nib_o,
  output logic                lcd_clk_o,
  output logic                row_sync_o,
  output logic                frame_sync_o,
  output logic [DATA_W-1:0]   open_bus_o
);
  localparam int CNT_W     = $clog2(PERIOD);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int COL_W     = $clog2(COLS);
  localparam int HOLD_LAST = COLS * 4 + 3;

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row;
  logic [CNT_W-1:0] rd_idx;
  slot_ctl_t        ctl;

  lcd_dma_timer #(.ROWS(ROWS), .PERIOD(PERIOD), .HOLD_LAST(HOLD_LAST)) u_timer (
    .clk_i, .rst_ni, .en_i(disp_en_i), .active_o(active), .cnt_o(cnt),
    .row_o(row), .row_sync_o, .frame_sync_o
  );

  lcd_dma_slot #(.COLS(COLS), .CNT_W(CNT_W)) u_slot (
    .clk_i, .rst_ni, .active_i(active), .cnt_i(cnt), .ctl_o(ctl), .rd_idx_o(rd_idx)
  );

  lcd_dma_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .ctl_i(ctl), .data_i(bus_data_i), .nib_o(lcd_nib_o), .pclk_o(lcd_clk_o)
  );

  lcd_open_bus #(.DATA_W(DATA_W)) u_ob (
    .clk_i, .rst_ni, .fetch_i(cpu_fetch_i), .hold_i(ctl.hold), .cap_i(ctl.cap),
    .data_i(bus_data_i), .ob_o(open_bus_o)
  );

  assign cpu_hold_o = ctl.hold;
  assign mem_rd_o   = ctl.rd;
  assign mem_addr_o = fb_base_i + (ADDR_W'(row) << COL_W) + ADDR_W'(rd_idx);

  AST_HOLD_AFTER_LAST_NIB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_hold_o) |-> $past(lcd_clk_o, 2)); // R6
endmodule

// File: tb/sim_lcd_row_dma.sv
module sim_lcd_row_dma;
  localparam int CLK_PERIOD = 10;
  localparam int PER  = 1024;
  localparam int ROWS = 64;

  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, fetch = 1'b0;
  logic [7:0]  cpu_data = 8'h00;
  logic [15:0] base = 16'h4A30;
  logic        d1 = 1'b0, d2 = 1'b0;
  logic [7:0]  m1 = 8'h00, m2 = 8'h00;
  logic [7:0]  bus;
  logic        hold, rd, pclk, rs, fs;
  logic [15:0] addr;
  logic [3:0]  nib;
  logic [7:0]  ob;

  assign bus = d2 ? m2 : cpu_data;

  lcd_row_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .disp_en_i(en), .fb_base_i(base),
    .bus_data_i(bus), .cpu_fetch_i(fetch), .cpu_hold_o(hold), .mem_addr_o(addr),
    .mem_rd_o(rd), .lcd_nib_o(nib), .lcd_clk_o(pclk), .row_sync_o(rs),
    .frame_sync_o(fs), .open_bus_o(ob)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    cyc = 0, vec = 0, err = 0, t0 = 0, m_off = 0;
  bit    m_run = 1'b0, mon_on = 1'b0;
  logic [7:0] exp_ob = 8'h00;
  string tag = "R7";

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    if (!ok) begin
      err++;
      $display("FAIL %s (%s) %s actual=%0h expected=%0h at cycle %0d", req, tag, what, act, exp, cyc);
    end
  endtask

  // memory answers a strobe with data valid in the following cycle
  always @(negedge clk) begin
    d1 <= rd; m1 <= pat(addr); d2 <= d1; m2 <= m1;
  end

  always @(negedge clk) begin
    int off, row, j;
    bit e_hold, e_rs, e_fs, e_rd, e_pclk, e_cap;
    logic [3:0]  e_nib;
    logic [15:0] e_addr;
    logic [7:0]  v;
    if (mon_on) begin
      cyc++;
      off = 0; row = 0;
      e_hold = 0; e_rs = 0; e_fs = 0; e_rd = 0; e_pclk = 0; e_cap = 0; e_nib = 4'h0; e_addr = 16'h0;
      if (m_run) begin
        off = (cyc - t0) % PER;
        row = ((cyc - t0) / PER) % ROWS;
        e_hold = off <= 67;
        e_rs   = off == 0;
        e_fs   = off == 0 && row == 0;
        e_rd   = off >= 1 && off <= 64 && (off - 1) % 4 == 0;
        e_addr = base + 16'(row * 16 + (off - 1) / 4);
        e_cap  = off >= 2 && off <= 65 && (off - 2) % 4 == 0;
        if (off >= 3 && off <= 66) begin
          j = off - 3;
          v = pat(base + 16'(row * 16 + j / 4));
          e_nib  = (j % 4 < 2) ? v[7:4] : v[3:0];
          e_pclk = j % 2 == 1;
        end
      end
      m_off = off;
      vec++;
      chk(hold == e_hold, "R6", "cpu_hold", int'(hold), int'(e_hold));
      chk(rs == e_rs, "R3", "row_sync", int'(rs), int'(e_rs));
      chk(fs == e_fs, "R3", "frame_sync", int'(fs), int'(e_fs));
      chk(rd == e_rd, "R4", "mem_rd", int'(rd), int'(e_rd));
      if (e_rd) chk(addr == e_addr, "R4", "mem_addr", int'(addr), int'(e_addr));
      chk(nib == e_nib, "R5", "lcd_nib", int'(nib), int'(e_nib));
      chk(pclk == e_pclk, "R5", "lcd_clk", int'(pclk), int'(e_pclk));
      chk(ob == exp_ob, "R10", "open_bus", int'(ob), int'(exp_ob));
      if (e_cap)               exp_ob = pat(base + 16'(row * 16 + (off - 2) / 4));
      else if (fetch && !e_hold) exp_ob = cpu_data;
      if (!m_run && en) begin
        m_run = 1'b1; t0 = cyc + 1;
      end else if (m_run && !en && off >= 67) begin
        m_run = 1'b0; // R8
      end
    end
  end

  initial begin
    int fc = 0;
    forever begin
      @(posedge clk); #1;
      fetch    = (fc % 3) == 0;
      cpu_data = 8'(fc * 37 + 11);
      fc++;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    vec++;
    chk(!hold && !rd && !pclk && !rs && !fs, "R1", "controls in reset",
        int'({hold, rd, pclk, rs, fs}), 0);
    vec++;
    chk(nib == 4'h0 && ob == 8'h00, "R1", "data in reset", int'({nib, ob}), 0);
    @(posedge clk); #1; rst_n = 1'b1; mon_on = 1'b1;
    tag = "R7"; repeat (300) @(posedge clk);
    #1; tag = "R2"; en = 1'b1;
    repeat (3000) @(posedge clk);
    tag = "R3"; repeat (PER * ROWS) @(posedge clk);
    tag = "R8";
    do @(posedge clk); while (!(m_run && m_off == 28));
    #1; en = 1'b0;
    repeat (2000) @(posedge clk);
    #1; tag = "R9"; en = 1'b1;
    repeat (3000) @(posedge clk);
    tag = "R7";
    do @(posedge clk); while (!(m_run && m_off == 500));
    #1; en = 1'b0;
    repeat (300) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule